// File: doc/BRIEF.md
# Interrupt Exception Bus Sequencer

Once an interrupt has been accepted, this block paces the bus activity of the exception that follows. It moves through a fixed schedule of thirteen phases lasting 56 clocks in total. The schedule includes two short penalty phases for misaligned bus accesses and a 12-clock vector fetch, during which the interrupt acknowledge is driven. For each phase the block emits a 4-bit phase code, read and write strobes, and the acknowledge. A one-clock done pulse marks the last clock.

The block also tracks the interrupt that is being serviced. If the same source asserts again during the first 24 clocks, which covers the lead-in and the vector fetch, the pending flag is set again and the presented vector number replaces the captured one. From clock 24 onward the vector is frozen, and a repeat assertion only sets the pending flag. The block moves no data: the strobes and codes tell the surrounding bus logic what to do and when.

Top module: `irq_exc_seq`

## Requirements
- R1: A synchronous reset returns the block to idle: phase code 0, and busy, read strobe, write strobe, acknowledge, done and pending all low.
- R2: When the block is idle, a start request is accepted at the clock edge. The next clock is sequence clock 0, in which busy is high and the phase code is 1.
- R3: The phases run as follows, given as code:length in clocks: 1:6 lead idle, 2:2 penalty, 3:4 write PC low, 4:12 vector fetch, 5:4 idle, 6:4 write status, 7:4 write PC high, 8:4 read vector address high, 9:4 read vector address low, 10:4 prefetch, 11:2 idle, 12:2 penalty, 13:4 prefetch.
- R4: The read strobe is high for the whole of phases 4, 8, 9, 10 and 13. The write strobe is high for the whole of phases 3, 6 and 7. The two strobes are never high together.
- R5: The acknowledge is high for sequence clocks 12 through 23 and at no other time.
- R6: The sequence lasts exactly 56 clocks. Done is high only in sequence clock 55, and in the next clock the block is idle with phase code 0.
- R7: A start request that arrives while busy, including during the done clock, has no effect on the phase progression or on the captured vector.
- R8: An accepted start captures the vector input. A re-assertion in sequence clocks 0 to 23 replaces the captured vector with the vector input, visible one clock later. Clock 23 is the last clock that can do this.
- R9: A re-assertion at sequence clock 24 or later leaves the captured vector unchanged.
- R10: An accepted start clears the pending flag. A re-assertion while busy sets it from the next clock onward.
- R11: A start in the clock right after the done clock is accepted, so sequences can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Interrupt accepted; begins a sequence when idle |
| vec_i | input | VEC_W | Vector number presented by the interrupt source |
| reirq_i | input | 1 | The serviced interrupt asserted again |
| busy_o | output | 1 | A sequence is in progress |
| phase_o | output | 4 | Current phase code, 0 when idle |
| rd_o | output | 1 | Read strobe for the current phase |
| wr_o | output | 1 | Write strobe for the current phase |
| iack_o | output | 1 | Interrupt acknowledge |
| done_o | output | 1 | High in the last clock of the sequence |
| vec_o | output | VEC_W | Captured vector number |
| pend_o | output | 1 | Pending flag of the serviced interrupt |

## Verification
Two functions can land in the same clock. One pair is the end of the vector fetch phase and a re-assertion of the interrupt. A re-assertion is driven in sequence clock 23, and the bench requires the new vector to appear in clock 24. A second one is driven in clock 24, and the bench requires the vector to stay unchanged while the pending flag rises. The other pair is the done clock and a fresh start request. The bench raises start in clock 55 and expects idle in clock 56. It then raises start in clock 56 and expects phase code 1 in the clock after.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

   typedef enum logic [3:0] {
      PH_OFF       = 4'd0,
      PH_LEAD_IDLE = 4'd1,
      PH_LEAD_PEN  = 4'd2,
      PH_WR_PCL    = 4'd3,
      PH_VEC_FETCH = 4'd4,
      PH_MID_IDLE  = 4'd5,
      PH_WR_SR     = 4'd6,
      PH_WR_PCH    = 4'd7,
      PH_RD_VAH    = 4'd8,
      PH_RD_VAL    = 4'd9,
      PH_PREF_A    = 4'd10,
      PH_TAIL_IDLE = 4'd11,
      PH_TAIL_PEN  = 4'd12,
      PH_PREF_B    = 4'd13
   } phase_t;

   localparam int     NUM_PHASES = 13;
   localparam int     CODE_W     = 4;
   localparam int     LEN_W      = 4;
   localparam int     SEQ_CLOCKS = 56;
   localparam int     ACK_FIRST  = 12;
   localparam int     VEC_WINDOW = 24;
   localparam phase_t PH_FIRST   = PH_LEAD_IDLE;
   localparam phase_t PH_LAST    = PH_PREF_B;

   // clocks spent in each phase
   function automatic logic [LEN_W-1:0] phase_len(input logic [CODE_W-1:0] c);
      case (c)
         4'd1:    phase_len = 4'd6;
         4'd2:    phase_len = 4'd2;
         4'd4:    phase_len = 4'd12;
         4'd11:   phase_len = 4'd2;
         4'd12:   phase_len = 4'd2;
         4'd0:    phase_len = 4'd0;
         default: phase_len = (c <= 4'd13) ? 4'd4 : 4'd0;
      endcase
   endfunction

   function automatic int total_len();
      int s;
      s = 0;
      for (int i = 1; i <= NUM_PHASES; i++) s += int'(phase_len(CODE_W'(i)));
      return s;
   endfunction

   function automatic logic code_is_rd(input logic [CODE_W-1:0] c);
      return (c == 4'd4) || (c == 4'd8) || (c == 4'd9) || (c == 4'd10) || (c == 4'd13);
   endfunction

   function automatic logic code_is_wr(input logic [CODE_W-1:0] c);
      return (c == 4'd3) || (c == 4'd6) || (c == 4'd7);
   endfunction

   function automatic logic code_is_ack(input logic [CODE_W-1:0] c);
      return c == 4'd4;
   endfunction

endpackage

// File: rtl/irq_seq_timer.sv
module irq_seq_timer
   import irq_seq_pkg::*;
#(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             accept,
   output phase_t           ph_o,
   output logic [CNT_W-1:0] k_o,
   output logic             final_o
);

   phase_t           ph_q;
   logic [LEN_W-1:0] rem_q;
   logic [CNT_W-1:0] k_q;
   logic             active;
   logic [CODE_W-1:0] nxt_code;

   assign active   = (ph_q != PH_OFF);
   assign nxt_code = CODE_W'(ph_q) + 4'd1;

   always_ff @(posedge clk) begin
      if (rst) begin
         ph_q  <= PH_OFF;
         rem_q <= '0;
         k_q   <= '0;
      end else if (!active) begin
         if (accept) begin
            ph_q  <= PH_FIRST;
            rem_q <= phase_len(CODE_W'(PH_FIRST)) - 4'd1;
            k_q   <= '0;
         end
      end else begin
         k_q <= k_q + 1'b1;
         if (rem_q == '0) begin
            if (ph_q == PH_LAST) begin
               ph_q <= PH_OFF;
            end else begin
               ph_q  <= phase_t'(nxt_code);
               rem_q <= phase_len(nxt_code) - 4'd1;
            end
         end else begin
            rem_q <= rem_q - 1'b1;
         end
      end
   end

   assign ph_o    = ph_q;
   assign k_o     = k_q;
   assign final_o = (ph_q == PH_LAST) && (rem_q == '0);

endmodule

// File: rtl/irq_seq_decode.sv
module irq_seq_decode
   import irq_seq_pkg::*;
(
   input  phase_t ph,
   output logic   rd,
   output logic   wr,
   output logic   ack
);

   localparam int NCODES = 1 << CODE_W;

   logic [NCODES-1:0] rd_mask;
   logic [NCODES-1:0] wr_mask;
   logic [NCODES-1:0] ack_mask;

   for (genvar gi = 0; gi < NCODES; gi++) begin : g_mask
      assign rd_mask[gi]  = code_is_rd(CODE_W'(gi));
      assign wr_mask[gi]  = code_is_wr(CODE_W'(gi));
      assign ack_mask[gi] = code_is_ack(CODE_W'(gi));
   end

   assign rd  = rd_mask[ph];
   assign wr  = wr_mask[ph];
   assign ack = ack_mask[ph];

endmodule

// File: rtl/irq_seq_vcap.sv
module irq_seq_vcap
   import irq_seq_pkg::*;
#(
   parameter int VEC_W = 8,
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             accept,
   input  logic             active,
   input  logic [CNT_W-1:0] k,
   input  logic             reirq,
   input  logic [VEC_W-1:0] vec_in,
   output logic [VEC_W-1:0] vec_q,
   output logic             pend_q
);

   localparam logic [CNT_W-1:0] WIN_END = CNT_W'(VEC_WINDOW);

   logic in_window;
   assign in_window = (k < WIN_END);

   always_ff @(posedge clk) begin
      if (rst) begin
         vec_q  <= '0;
         pend_q <= 1'b0;
      end else if (accept) begin
         vec_q  <= vec_in;
         pend_q <= 1'b0;
      end else if (active && reirq) begin
         pend_q <= 1'b1;
         if (in_window) vec_q <= vec_in;
      end
   end

endmodule

// File: rtl/irq_exc_seq.sv
module irq_exc_seq
   import irq_seq_pkg::*;
#(
   parameter int VEC_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start_i,
   input  logic [VEC_W-1:0] vec_i,
   input  logic             reirq_i,
   output logic             busy_o,
   output logic [3:0]       phase_o,
   output logic             rd_o,
   output logic             wr_o,
   output logic             iack_o,
   output logic             done_o,
   output logic [VEC_W-1:0] vec_o,
   output logic             pend_o
);

   localparam int CNT_W = $clog2(SEQ_CLOCKS + 1);

   if (VEC_W < 1) begin : g_bad_vec_w
      $error("irq_exc_seq: VEC_W must be at least 1");
   end
   if (total_len() != SEQ_CLOCKS) begin : g_bad_sched
      $error("irq_exc_seq: phase lengths do not add up to SEQ_CLOCKS");
   end
   if (VEC_WINDOW > SEQ_CLOCKS) begin : g_bad_window
      $error("irq_exc_seq: vector window exceeds the sequence");
   end

   phase_t           ph;
   logic [CNT_W-1:0] k;
   logic             last_clk;
   logic             active;
   logic             accept;

   assign active = (ph != PH_OFF);
   assign accept = start_i && !active;

   irq_seq_timer #(.CNT_W(CNT_W)) u_timer (
      .clk     (clk),
      .rst     (rst),
      .accept  (accept),
      .ph_o    (ph),
      .k_o     (k),
      .final_o (last_clk)
   );

   irq_seq_decode u_decode (
      .ph  (ph),
      .rd  (rd_o),
      .wr  (wr_o),
      .ack (iack_o)
   );

   irq_seq_vcap #(.VEC_W(VEC_W), .CNT_W(CNT_W)) u_vcap (
      .clk    (clk),
      .rst    (rst),
      .accept (accept),
      .active (active),
      .k      (k),
      .reirq  (reirq_i),
      .vec_in (vec_i),
      .vec_q  (vec_o),
      .pend_q (pend_o)
   );

   assign busy_o  = active;
   assign phase_o = CODE_W'(ph);
   assign done_o  = last_clk;

endmodule

// File: rtl/irq_exc_seq_chk.sv
module irq_exc_seq_chk #(
   parameter int VEC_W = 8
) (
   input logic             clk,
   input logic             rst,
   input logic             start_i,
   input logic             reirq_i,
   input logic             busy_o,
   input logic [3:0]       phase_o,
   input logic             rd_o,
   input logic             wr_o,
   input logic             iack_o,
   input logic             done_o,
   input logic [VEC_W-1:0] vec_o,
   input logic             pend_o
);

   logic [6:0] k_chk;

   always_ff @(posedge clk) begin
      if (rst)         k_chk <= '0;
      else if (busy_o) k_chk <= k_chk + 1'b1;
      else             k_chk <= '0;
   end

   // R2
   start_enters_first_chk: assert property (@(posedge clk) disable iff (rst)
      (!busy_o && start_i) |=> (busy_o && phase_o == 4'd1));

   // R4
   strobe_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0({rd_o, wr_o}));

   // R5
   ack_window_chk: assert property (@(posedge clk) disable iff (rst)
      iack_o |-> (k_chk >= 7'd12 && k_chk <= 7'd23 && rd_o));

   // R6
   done_position_chk: assert property (@(posedge clk) disable iff (rst)
      done_o |-> (busy_o && k_chk == 7'd55));

   // R6
   done_then_idle_chk: assert property (@(posedge clk) disable iff (rst)
      done_o |=> (!busy_o && phase_o == 4'd0));

   // R7
   busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
      (busy_o && !done_o && start_i) |=> busy_o);

   // R9
   vec_frozen_chk: assert property (@(posedge clk) disable iff (rst)
      (busy_o && k_chk >= 7'd25) |-> $stable(vec_o));

   // R10
   pend_set_chk: assert property (@(posedge clk) disable iff (rst)
      (busy_o && reirq_i) |=> pend_o);

endmodule

bind irq_exc_seq irq_exc_seq_chk #(.VEC_W(VEC_W)) u_chk (.*);

// File: tb/irq_exc_seq_bench.sv
module irq_exc_seq_bench;

   localparam int CLK_PERIOD = 10;
   localparam int VW = 8;

   // {code, length, rd, wr, ack}
   localparam logic [10:0] PH_TBL [0:12] = '{
      {4'd1,  4'd6,  3'b000},
      {4'd2,  4'd2,  3'b000},
      {4'd3,  4'd4,  3'b010},
      {4'd4,  4'd12, 3'b101},
      {4'd5,  4'd4,  3'b000},
      {4'd6,  4'd4,  3'b010},
      {4'd7,  4'd4,  3'b010},
      {4'd8,  4'd4,  3'b100},
      {4'd9,  4'd4,  3'b100},
      {4'd10, 4'd4,  3'b100},
      {4'd11, 4'd2,  3'b000},
      {4'd12, 4'd2,  3'b000},
      {4'd13, 4'd4,  3'b100}
   };

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          start_i = 1'b0;
   logic [VW-1:0] vec_i = '0;
   logic          reirq_i = 1'b0;
   logic          busy_o, rd_o, wr_o, iack_o, done_o, pend_o;
   logic [3:0]    phase_o;
   logic [VW-1:0] vec_o;

   int n_cmp = 0;
   int n_bad = 0;
   int kcur  = 0;
   logic [10:0] ent;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_exc_seq #(.VEC_W(VW)) u_irq_exc_seq (
      .clk(clk), .rst(rst), .start_i(start_i), .vec_i(vec_i), .reirq_i(reirq_i),
      .busy_o(busy_o), .phase_o(phase_o), .rd_o(rd_o), .wr_o(wr_o),
      .iack_o(iack_o), .done_o(done_o), .vec_o(vec_o), .pend_o(pend_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s k=%0d actual=%0h expected=%0h", req, kcur, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
      kcur++;
   endtask

   task automatic kick(input logic [VW-1:0] v);
      start_i = 1'b1;
      vec_i   = v;
      @(negedge clk);
      start_i = 1'b0;
      kcur    = 0;
   endtask

   task automatic run_to(input int k);
      while (kcur < k) step();
   endtask

   task automatic reirq_at(input logic [VW-1:0] v);
      reirq_i = 1'b1;
      vec_i   = v;
      step();
      reirq_i = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_bad++;
      $display("FAIL watchdog R6 actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 phase", phase_o, 0);
      chk("R1 busy", busy_o, 0);
      chk("R1 strobes", {rd_o, wr_o, iack_o, done_o}, 0);
      chk("R1 pend", pend_o, 0);
      rst = 1'b0;
      @(negedge clk);

      // R2..R6 walk over the phase table
      kick(8'h1A);
      chk("R2 busy", busy_o, 1);
      chk("R8 captured vector", vec_o, 8'h1A);
      chk("R10 pend cleared", pend_o, 0);
      for (int p = 0; p < 13; p++) begin
         ent = PH_TBL[p];
         for (int j = 0; j < int'(ent[6:3]); j++) begin
            chk("R3 phase code", phase_o, ent[10:7]);
            chk("R4 rd/wr", {rd_o, wr_o}, ent[2:1]);
            chk("R5 iack", iack_o, ent[0]);
            chk("R6 done", done_o, (kcur == 55));
            step();
         end
      end
      chk("R6 idle after 56", {busy_o, phase_o}, 0);
      chk("R6 done low", done_o, 0);

      // R7 start while busy
      @(negedge clk);
      kick(8'h11);
      run_to(10);
      start_i = 1'b1;
      vec_i   = 8'h99;
      run_to(13);
      start_i = 1'b0;
      chk("R7 phase not restarted", phase_o, 4);
      chk("R7 vector kept", vec_o, 8'h11);
      run_to(55);
      chk("R6 done at 55", done_o, 1);
      start_i = 1'b1;
      step();
      start_i = 1'b0;
      chk("R7 start in done clock ignored", busy_o, 0);
      @(negedge clk);

      // R8 R9 R10 vector window
      kick(8'h20);
      run_to(5);
      reirq_at(8'h21);
      chk("R8 vector replaced", vec_o, 8'h21);
      chk("R10 pend set", pend_o, 1);
      run_to(23);
      reirq_at(8'h23);
      chk("R8 last window clock", vec_o, 8'h23);
      reirq_at(8'h24);
      chk("R9 vector frozen", vec_o, 8'h23);
      chk("R9 pend still set", pend_o, 1);
      run_to(40);
      reirq_at(8'h40);
      chk("R9 late reassert", vec_o, 8'h23);
      run_to(56);
      chk("R11 idle at 56", busy_o, 0);

      // R11 back to back
      kick(8'h30);
      chk("R11 restart phase", phase_o, 1);
      chk("R11 vector", vec_o, 8'h30);
      chk("R10 pend cleared on start", pend_o, 0);

      // R1 reset mid sequence
      run_to(10);
      rst = 1'b1;
      step();
      rst = 1'b0;
      chk("R1 mid reset phase", phase_o, 0);
      chk("R1 mid reset outputs", {busy_o, rd_o, wr_o, iack_o, done_o, pend_o}, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule